// File: doc/BRIEF.md
# Time-Aligned Periodic Clock Output

This block produces a square wave whose edges fall at exact instants of a free-running 64-bit system time. Software loads an absolute target time and a half-period, both as pairs of 32-bit words, then enables the output. In every clock cycle the block compares the system time with the target. When the time has reached the target, the output level inverts and the target moves forward by one half-period. With a half-period of half a second, expressed in raw time units, the result is a pulse-per-second signal locked to the time base. Software works out where the first edge falls.

Each output edge can raise a one-cycle interrupt pulse. A pin-configuration register sets the pin direction and selects whether the pin carries the timing waveform. Writing zero to the control register stops the wave and returns the pin to low. The target and half-period registers can only be written while the output is disabled, so reprogramming has to follow a stop.

Top module: `tac_clkout`

## Requirements
- R1: After reset, pin_out, pin_oe and irq_pulse are 0 and every register reads 0.
- R2: The target time is written through word address 1 (bits 31:0) and word address 2 (bits 63:32). Both words read back at the same addresses, and the readback shows the target as it advances.
- R3: The half-period is written and read back at word address 3 (bits 31:0) and word address 4 (bits 63:32).
- R4: Control register (address 0) bit 0 enables the output and bit 1 enables time-aligned edges. While both bits are 1 and the unsigned value of sys_time is greater than or equal to the target, the wave inverts at the next clock edge and the target becomes the old target plus the half-period.
- R5: Control bit 2 unmasks the interrupt. irq_pulse is high for exactly the one cycle in which the wave shows a new level, and only if bit 2 was set when the match happened.
- R6: A control write with bit 0 clear forces the wave low at the next clock edge. Enabling the output produces no edge until the first compare match.
- R7: While control bit 0 is 1, writes to addresses 1 to 4 are ignored and the readback does not change.
- R8: Pin configuration register (address 5): bit 0 drives pin_oe. pin_out carries the wave only when bits 0 and 1 are both 1 and is 0 otherwise.
- R9: When sys_time is already several half-periods past the target, the block makes one toggle per cycle and keeps toggling on the following cycles until the target passes the time again.
- R10: The compare is a full 64-bit unsigned compare, and the advance carries from the low word into the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Running system time in raw units |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| pin_out | output | 1 | Output pin level |
| pin_oe | output | 1 | Output pin drive enable |
| irq_pulse | output | 1 | One-cycle pulse for each output edge |

## Verification
A time ramp that steps by one unit shows whether each edge lands in the first cycle at or after the target and whether the spacing equals the half-period. A time held several half-periods past the target separates one-toggle-per-cycle catch-up from skipping or stalling. Values that straddle bit 63 and the 32-bit word boundary expose a signed compare or a lost carry. Random time steps, interrupt-mask changes and writes blocked during operation, all checked against a cycle model, catch mistakes in priority and masking.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int CTL_EN   = 0;
  localparam int CTL_SYNC = 1;
  localparam int CTL_IRQ  = 2;
  localparam int CTL_BITS = 3;
  localparam int PIN_DIR  = 0;
  localparam int PIN_SEL  = 1;
  localparam int ADDR_CTRL = 0;

  function automatic int addr_tgt(input int w);
    return 1 + w;
  endfunction

  function automatic int addr_hp(input int nw, input int w);
    return 1 + nw + w;
  endfunction

  function automatic int addr_pin(input int nw);
    return 1 + 2 * nw;
  endfunction

  function automatic int addr_bits(input int nw);
    return $clog2(2 + 2 * nw);
  endfunction

  // unsigned "time has reached target"
  function automatic logic reached(input logic [63:0] now, input logic [63:0] tgt);
    return now >= tgt;
  endfunction

  function automatic logic [63:0] advance(input logic [63:0] tgt, input logic [63:0] hp);
    return tgt + hp;
  endfunction
endpackage

// File: rtl/tac_regs.sv
module tac_regs
  import tac_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int NWORDS = 2,
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [REG_W-1:0]        wdata,
  input  logic [NWORDS*REG_W-1:0] tgt_q,
  output logic                    out_en,
  output logic                    sync_en,
  output logic                    irq_en,
  output logic                    stop,
  output logic                    pin_dir,
  output logic                    pin_sel,
  output logic [NWORDS*REG_W-1:0] hp_q,
  output logic [NWORDS-1:0]       tgt_ld,
  output logic [REG_W-1:0]        rdata
);
  logic [CTL_BITS-1:0] ctrl_q;
  logic [1:0]          pin_q;
  logic                wr_ctrl, wr_pin;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(ADDR_CTRL));
  assign wr_pin  = wr_en && (addr == ADDR_W'(addr_pin(NWORDS)));
  assign stop    = wr_ctrl && !wdata[CTL_EN];
  assign out_en  = ctrl_q[CTL_EN];
  assign sync_en = ctrl_q[CTL_SYNC];
  assign irq_en  = ctrl_q[CTL_IRQ];
  assign pin_dir = pin_q[PIN_DIR];
  assign pin_sel = pin_q[PIN_SEL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pin_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[CTL_BITS-1:0];
      if (wr_pin)  pin_q  <= wdata[1:0];
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic hp_ld;
    assign tgt_ld[w] = wr_en && !out_en && (addr == ADDR_W'(addr_tgt(w)));
    assign hp_ld     = wr_en && !out_en && (addr == ADDR_W'(addr_hp(NWORDS, w)));
    always_ff @(posedge clk) begin
      if (!rst_n)      hp_q[w*REG_W +: REG_W] <= '0;
      else if (hp_ld)  hp_q[w*REG_W +: REG_W] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_CTRL))       rdata = REG_W'(ctrl_q);
    if (addr == ADDR_W'(addr_pin(NWORDS))) rdata = REG_W'(pin_q);
    for (int w = 0; w < NWORDS; w++) begin
      if (addr == ADDR_W'(addr_tgt(w)))        rdata = tgt_q[w*REG_W +: REG_W];
      if (addr == ADDR_W'(addr_hp(NWORDS, w))) rdata = hp_q[w*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/tac_sched.sv
module tac_sched
  import tac_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int NWORDS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [NWORDS*REG_W-1:0] now,
  input  logic [NWORDS*REG_W-1:0] hp,
  input  logic [NWORDS-1:0]       ld,
  input  logic [REG_W-1:0]        wdata,
  output logic [NWORDS*REG_W-1:0] tgt_q,
  output logic                    fire
);
  assign fire = run && reached(now, tgt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (fire) begin
      tgt_q <= advance(tgt_q, hp);
    end else begin
      for (int w = 0; w < NWORDS; w++)
        if (ld[w]) tgt_q[w*REG_W +: REG_W] <= wdata;
    end
  end
endmodule

// File: rtl/tac_wave.sv
module tac_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic stop,
  input  logic irq_en,
  input  logic pin_dir,
  input  logic pin_sel,
  output logic wave_q,
  output logic pin_out,
  output logic pin_oe,
  output logic irq_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_q    <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= fire && irq_en;
      if (stop)      wave_q <= 1'b0;
      else if (fire) wave_q <= ~wave_q;
    end
  end

  assign pin_oe  = pin_dir;
  assign pin_out = (pin_dir && pin_sel) ? wave_q : 1'b0;
endmodule

// File: rtl/tac_clkout.sv
module tac_clkout
  import tac_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = addr_bits(TIME_W / REG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq_pulse
);
  localparam int NWORDS = TIME_W / REG_W;

  logic              out_en, sync_en, irq_en, stop, pin_dir, pin_sel;
  logic              fire, wave_q;
  logic [TIME_W-1:0] tgt_q, hp_q;
  logic [NWORDS-1:0] tgt_ld;

  tac_regs #(.REG_W(REG_W), .NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .tgt_q(tgt_q), .out_en(out_en), .sync_en(sync_en), .irq_en(irq_en), .stop(stop),
    .pin_dir(pin_dir), .pin_sel(pin_sel), .hp_q(hp_q), .tgt_ld(tgt_ld), .rdata(bus_rdata)
  );

  tac_sched #(.REG_W(REG_W), .NWORDS(NWORDS)) u_sched (
    .clk(clk), .rst_n(rst_n), .run(out_en && sync_en), .now(sys_time), .hp(hp_q),
    .ld(tgt_ld), .wdata(bus_wdata), .tgt_q(tgt_q), .fire(fire)
  );

  tac_wave u_wave (
    .clk(clk), .rst_n(rst_n), .fire(fire), .stop(stop), .irq_en(irq_en),
    .pin_dir(pin_dir), .pin_sel(pin_sel), .wave_q(wave_q), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_pulse(irq_pulse)
  );
endmodule

// File: rtl/tac_chk.sv
module tac_chk #(
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic              stop,
  input logic              wave_q,
  input logic              out_en,
  input logic              irq_en,
  input logic              irq_pulse,
  input logic [TIME_W-1:0] tgt_q,
  input logic [TIME_W-1:0] hp_q
);
  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !stop) |=> (wave_q != $past(wave_q)));

  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (tgt_q == $past(tgt_q) + $past(hp_q)));

  assert_irq_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (wave_q != $past(wave_q)));

  assert_irq_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(irq_en));

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !wave_q);

  assert_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !fire) |=> $stable(tgt_q));
endmodule

bind tac_clkout tac_chk #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .stop(stop), .wave_q(wave_q),
  .out_en(out_en), .irq_en(irq_en), .irq_pulse(irq_pulse), .tgt_q(tgt_q), .hp_q(hp_q)
);

// File: tb/tac_clkout_tb.sv
module tac_clkout_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] sys_time;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pin_out, pin_oe, irq_pulse;

  always #10 clk = ~clk;

  tac_clkout u_dut (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_pulse(irq_pulse)
  );

  int n_chk = 0;
  int n_fail = 0;
  int toggles = 0;
  logic last_pin = 1'b0;

  logic [2:0]  m_ctrl;
  logic [1:0]  m_cfg;
  logic [63:0] m_tgt, m_hp;
  logic        m_wave, m_irq;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_pin();
    return (m_cfg == 2'b11) ? m_wave : 1'b0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {29'd0, m_ctrl};
      3'd1: return m_tgt[31:0];
      3'd2: return m_tgt[63:32];
      3'd3: return m_hp[31:0];
      3'd4: return m_hp[63:32];
      3'd5: return {30'd0, m_cfg};
      default: return 32'd0;
    endcase
  endfunction

  // cycle model built from R4..R8
  task automatic model_edge();
    logic hit;
    hit = m_ctrl[0] && m_ctrl[1] && (sys_time >= m_tgt);
    m_irq = hit && m_ctrl[2];
    if (bus_wr && bus_addr == 3'd0 && !bus_wdata[0]) m_wave = 1'b0;
    else if (hit) m_wave = ~m_wave;
    if (hit) m_tgt = m_tgt + m_hp;
    else if (!m_ctrl[0] && bus_wr) begin
      if (bus_addr == 3'd1) m_tgt[31:0]  = bus_wdata;
      if (bus_addr == 3'd2) m_tgt[63:32] = bus_wdata;
    end
    if (!m_ctrl[0] && bus_wr) begin
      if (bus_addr == 3'd3) m_hp[31:0]  = bus_wdata;
      if (bus_addr == 3'd4) m_hp[63:32] = bus_wdata;
    end
    if (bus_wr && bus_addr == 3'd0) m_ctrl = bus_wdata[2:0];
    if (bus_wr && bus_addr == 3'd5) m_cfg  = bus_wdata[1:0];
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R4/R8 pin_out", {63'd0, pin_out}, {63'd0, exp_pin()});
    check("R8 pin_oe", {63'd0, pin_oe}, {63'd0, m_cfg[0]});
    check("R5 irq_pulse", {63'd0, irq_pulse}, {63'd0, m_irq});
    if (pin_out != last_pin) toggles++;
    last_pin = pin_out;
    bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, {32'd0, bus_rdata}, {32'd0, exp});
    check({tag, " model"}, {32'd0, bus_rdata}, {32'd0, exp_read(a)});
  endtask

  task automatic run(input int n, input logic [63:0] inc);
    for (int i = 0; i < n; i++) begin
      sys_time = sys_time + inc;
      step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    rst_n = 1'b0; sys_time = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_ctrl = '0; m_cfg = '0; m_tgt = '0; m_hp = '0; m_wave = 1'b0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out", {63'd0, pin_out}, 64'd0);
    check("R1 pin_oe", {63'd0, pin_oe}, 64'd0);
    check("R1 irq", {63'd0, irq_pulse}, 64'd0);
    for (int a = 0; a < 6; a++) rd("R1 reg reset", 3'(a), 32'd0);
    rst_n = 1'b1;

    // R2 / R3 word access
    wr(3'd1, 32'h89AB_CDEF); wr(3'd2, 32'h0123_4567);
    wr(3'd3, 32'h1111_2222); wr(3'd4, 32'h0000_0003);
    rd("R2 tgt lo", 3'd1, 32'h89AB_CDEF); rd("R2 tgt hi", 3'd2, 32'h0123_4567);
    rd("R3 hp lo", 3'd3, 32'h1111_2222);  rd("R3 hp hi", 3'd4, 32'h0000_0003);

    // R4 / R6 aligned edges on a unit ramp
    wr(3'd5, 32'd3);
    wr(3'd1, 32'd100); wr(3'd2, 32'd0); wr(3'd3, 32'd50); wr(3'd4, 32'd0);
    sys_time = 64'd90;
    wr(3'd0, 32'd7);
    check("R6 no edge on enable", {63'd0, pin_out}, 64'd0);
    run(9, 64'd1);                       // time 99
    check("R4 before target", {63'd0, pin_out}, 64'd0);
    run(1, 64'd1);                       // time 100: match
    check("R4 edge at target", {63'd0, pin_out}, 64'd1);
    check("R5 irq on edge", {63'd0, irq_pulse}, 64'd1);
    run(10, 64'd1);
    rd("R4 target advanced", 3'd1, 32'd150);

    // R7 writes blocked while running
    wr(3'd1, 32'd5); wr(3'd3, 32'd7);
    rd("R7 tgt write ignored", 3'd1, 32'd150);
    rd("R7 hp write ignored", 3'd3, 32'd50);

    // R9 catch-up: time five half-periods past the target
    sys_time = 64'd400;
    toggles = 0;
    run(10, 64'd0);
    check("R9 catch-up toggles", 64'(toggles), 64'd6);
    rd("R9 target after catch-up", 3'd1, 32'd450);

    // R5 masked interrupt
    wr(3'd0, 32'd3);
    sys_time = 64'd450;
    step();
    check("R5 masked irq", {63'd0, irq_pulse}, 64'd0);

    // R8 pin configuration
    wr(3'd5, 32'd1);
    run(60, 64'd1);
    check("R8 pin gated", {63'd0, pin_out}, 64'd0);
    wr(3'd5, 32'd0);
    check("R8 oe off", {63'd0, pin_oe}, 64'd0);
    wr(3'd5, 32'd3);

    // R6 stop and re-enable without a match
    wr(3'd0, 32'd0);
    check("R6 stop low", {63'd0, pin_out}, 64'd0);
    wr(3'd1, sys_time[31:0] + 32'd1000); wr(3'd2, sys_time[63:32]);
    wr(3'd0, 32'd7);
    run(10, 64'd1);
    check("R6 quiet until match", {63'd0, pin_out}, 64'd0);

    // R10 bit 63 compare and carry into the high word
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0); wr(3'd2, 32'h8000_0000); wr(3'd3, 32'h10); wr(3'd4, 32'd0);
    sys_time = 64'h7FFF_FFFF_FFFF_FFFF;
    wr(3'd0, 32'd7);
    run(3, 64'd0);
    check("R10 below bit63 target", {63'd0, pin_out}, 64'd0);
    sys_time = 64'h8000_0000_0000_0000;
    step();
    check("R10 bit63 match", {63'd0, pin_out}, 64'd1);
    rd("R10 tgt lo", 3'd1, 32'h10);
    wr(3'd0, 32'd0);
    wr(3'd1, 32'hFFFF_FFF0); wr(3'd2, 32'd0); wr(3'd3, 32'h20);
    sys_time = 64'h0000_0000_FFFF_FFF0;
    wr(3'd0, 32'd7);
    step();
    rd("R10 carry hi", 3'd2, 32'd1);
    rd("R10 carry lo", 3'd1, 32'h10);

    // random phase against the model
    wr(3'd0, 32'd0);
    sys_time = 64'd5000;
    wr(3'd1, 32'd5000 + ($urandom % 50)); wr(3'd2, 32'd0);
    wr(3'd3, 32'd1 + ($urandom % 20));
    wr(3'd0, 32'd3 | (($urandom % 2) << 2));
    for (int i = 0; i < 400; i++) begin
      sys_time = sys_time + 64'($urandom % 4);
      if ($urandom % 16 == 0) begin
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'd3 | (($urandom % 2) << 2);
      end else if ($urandom % 32 == 0) begin
        bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = $urandom;   // R7 blocked
      end
      step();
    end
    rd("R4 random target", 3'd1, m_tgt[31:0]);

    summary();
    $finish;
  end
endmodule